// File: doc/BRIEF.md
# Subroutine Link and Frame Mark Sequencer

This block carries out the control-transfer part of two instructions in a 16-bit minicomputer-style CPU. The first is a jump to subroutine with a selectable link register. The second is a stack-frame mark that unwinds a caller's argument area. When the CPU pulses `start`, the block takes in the instruction word, an effective address that has already been computed, and a snapshot of the eight general registers. It then moves through a fixed sequence of states. Each state makes one register-file write or one single-beat stack memory access. A stack access waits on `mem_ready` before the sequence moves on.

For the jump, the effective address becomes the new PC as it is. It is not read from memory. Encodings that cannot be executed are rejected with a one-cycle reserved-instruction trap pulse and cause no register or memory activity. These encodings are: SP as the link register, a link register equal to the destination register when the link is not the PC, and register-direct destination mode. The block has no condition-code output, so neither instruction touches the flags.

States: `S_IDLE`, `S_TRAP`, `S_J_PUSH`, `S_J_SP`, `S_J_LINK`, `S_J_PC`, `S_M_SP`, `S_M_PC`, `S_M_POP`, `S_M_R5`, `S_M_SPINC`, `S_DONE`.

Transitions:
- `S_IDLE` goes to `S_TRAP` on start with an illegal word, to `S_J_PUSH` on a legal jump, and to `S_M_SP` on a mark.
- `S_J_PUSH` stays put until ready, then goes to `S_J_SP`. The jump then runs `S_J_SP` → `S_J_LINK` → `S_J_PC` → `S_DONE`.
- The mark runs `S_M_SP` → `S_M_PC` → `S_M_POP`. `S_M_POP` stays put until ready, then goes on through `S_M_R5` → `S_M_SPINC` → `S_DONE`.
- `S_TRAP` and `S_DONE` return to `S_IDLE`.

Top module: `link_mark_seq`

## Requirements
- R1: At start, a word whose bits 15..9 are 0000100 is a jump, with the link register in bits 8..6, the destination mode in bits 5..3 and the destination register in bits 2..0. A word whose bits 15..6 are 0000110100 is a mark, with n in bits 5..0. Any other word produces a trap and no writes.
- R2: A jump whose link register is 6 (SP) traps and makes no memory access and no register write.
- R3: A jump whose link register equals its destination register, with the link not 7 (PC), traps with no writes.
- R4: A jump whose destination mode is 0 traps with no writes.
- R5: The trap is high for exactly one cycle, the cycle after start, and `done` does not go high for that operation.
- R6: A legal jump writes the old link-register value to memory at SP-2. It then writes SP←SP-2, then link←PC, then PC←EA, in that order, one register write per cycle.
- R7: A jump loads the effective address into the PC unchanged and makes no memory read.
- R8: A mark writes SP←PC+2n (mod 2^16), then PC←R5. It then reads memory at the new SP, writes R5←the read word, and writes SP←new SP+2.
- R9: While `mem_req` is high and `mem_ready` is low, the request, direction, address and write data stay unchanged and the sequence does not advance.
- R10: `busy` is high from the cycle after an accepted start through the `done` or trap cycle. `done` is a one-cycle pulse after the last write. A start while busy is ignored.
- R11: Bit 0 of `mem_addr` is 0 whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| instr | input | 16 | Instruction word |
| eff_addr | input | 16 | Precomputed destination effective address |
| reg_bus | input | 128 | Registers R0..R7, R0 in the low 16 bits |
| mem_req | output | 1 | Stack memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Stack byte address (even) |
| mem_wdata | output | 16 | Word to push |
| mem_rdata | input | 16 | Word read on a pop |
| mem_ready | input | 1 | Access completes this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 3 | Register number written |
| rf_wdata | output | 16 | Value written |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle reserved-instruction pulse |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives while a stalled stack access holds the sequence in place. In that case the snapshot must not be retaken and no trap may leak out. The bench brings this about by making the memory model hold `mem_ready` low for several cycles during a jump's push. While the push waits, it pulses `start` with an illegal word and checks that the event stream is unchanged. A mark with PC near 0xFFF0 and n=63 covers the wrap of the frame arithmetic.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_TRAP,
        S_J_PUSH, S_J_SP, S_J_LINK, S_J_PC,
        S_M_SP, S_M_PC, S_M_POP, S_M_R5, S_M_SPINC,
        S_DONE
    } lms_state_e;

    localparam logic [6:0] JSR_PATTERN  = 7'b0000100;
    localparam logic [9:0] MARK_PATTERN = 10'b0000110100;
endpackage

// File: rtl/lms_decode.sv
module lms_decode
    import lms_pkg::*;
#(
    parameter int W      = 16,
    parameter int RI     = 3,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  logic [W-1:0]  instr,
    output logic          is_jsr,
    output logic          is_mark,
    output logic          illegal,
    output logic [RI-1:0] link_sel,
    output logic [5:0]    mark_n
);
    logic [RI-1:0] dst_reg;
    logic [2:0]    dst_mode;
    logic          bad_jsr;

    assign is_jsr   = (instr[15:9] == JSR_PATTERN);
    assign is_mark  = (instr[15:6] == MARK_PATTERN);
    assign link_sel = instr[8:6];
    assign dst_reg  = instr[2:0];
    assign dst_mode = instr[5:3];
    assign mark_n   = instr[5:0];

    always_comb begin
        bad_jsr = 1'b0;
        if (link_sel == RI'(SP_IDX))
            bad_jsr = 1'b1;
        if ((link_sel == dst_reg) && (link_sel != RI'(PC_IDX)))
            bad_jsr = 1'b1;
        if (dst_mode == 3'd0)
            bad_jsr = 1'b1;
    end

    assign illegal = !(is_jsr || is_mark) || (is_jsr && bad_jsr);
endmodule

// File: rtl/lms_addr.sv
module lms_addr #(
    parameter int W = 16
) (
    input  logic [W-1:0] sp_val,
    input  logic [W-1:0] pc_val,
    input  logic [5:0]   n_val,
    output logic [W-1:0] push_addr,
    output logic [W-1:0] frame_sp,
    output logic [W-1:0] after_pop
);
    localparam logic [W-1:0] WORD_BYTES = W'(2);

    assign push_addr = sp_val - WORD_BYTES;
    assign frame_sp  = pc_val + W'({n_val, 1'b0});
    assign after_pop = frame_sp + WORD_BYTES;
endmodule

// File: rtl/link_mark_seq.sv
module link_mark_seq
    import lms_pkg::*;
#(
    parameter int W      = 16,
    parameter int NREG   = 8,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7,
    parameter int FP_IDX = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [W-1:0]        instr,
    input  logic [W-1:0]        eff_addr,
    input  logic [NREG*W-1:0]   reg_bus,
    output logic                mem_req,
    output logic                mem_we,
    output logic [W-1:0]        mem_addr,
    output logic [W-1:0]        mem_wdata,
    input  logic [W-1:0]        mem_rdata,
    input  logic                mem_ready,
    output logic                rf_we,
    output logic [$clog2(NREG)-1:0] rf_idx,
    output logic [W-1:0]        rf_wdata,
    output logic                busy,
    output logic                done,
    output logic                trap
);
    localparam int RI = $clog2(NREG);

    lms_state_e st, nx;

    logic [W-1:0] regs [NREG];
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign regs[g] = reg_bus[g*W +: W];
    end

    logic          is_jsr, is_mark, illegal;
    logic [RI-1:0] link_sel;
    logic [5:0]    mark_n;

    lms_decode #(.W(W), .RI(RI), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_dec (
        .instr(instr), .is_jsr(is_jsr), .is_mark(is_mark), .illegal(illegal),
        .link_sel(link_sel), .mark_n(mark_n)
    );

    logic [RI-1:0] lnk_q;
    logic [W-1:0]  lval_q, pc_q, sp_q, r5_q, ea_q, pop_q;
    logic [5:0]    n_q;
    logic [W-1:0]  push_addr, frame_sp, after_pop, raw_addr;

    lms_addr #(.W(W)) u_addr (
        .sp_val(sp_q), .pc_val(pc_q), .n_val(n_q),
        .push_addr(push_addr), .frame_sp(frame_sp), .after_pop(after_pop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:    if (start) nx = illegal ? S_TRAP : (is_jsr ? S_J_PUSH : S_M_SP);
            S_TRAP:    nx = S_IDLE;
            S_J_PUSH:  if (mem_ready) nx = S_J_SP;
            S_J_SP:    nx = S_J_LINK;
            S_J_LINK:  nx = S_J_PC;
            S_J_PC:    nx = S_DONE;
            S_M_SP:    nx = S_M_PC;
            S_M_PC:    nx = S_M_POP;
            S_M_POP:   if (mem_ready) nx = S_M_R5;
            S_M_R5:    nx = S_M_SPINC;
            S_M_SPINC: nx = S_DONE;
            S_DONE:    nx = S_IDLE;
            default:   nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lnk_q <= '0; lval_q <= '0; pc_q <= '0; sp_q <= '0;
            r5_q <= '0; ea_q <= '0; n_q <= '0; pop_q <= '0;
        end else begin
            if (st == S_IDLE && start) begin
                lnk_q  <= link_sel;
                lval_q <= regs[link_sel];
                pc_q   <= regs[PC_IDX];
                sp_q   <= regs[SP_IDX];
                r5_q   <= regs[FP_IDX];
                ea_q   <= eff_addr;
                n_q    <= mark_n;
            end
            if (st == S_M_POP && mem_ready)
                pop_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; raw_addr = '0; mem_wdata = '0;
        rf_we = 1'b0; rf_idx = '0; rf_wdata = '0;
        done = 1'b0; trap = 1'b0;
        busy = (st != S_IDLE);
        unique case (st)
            S_IDLE:    ;
            S_TRAP:    trap = 1'b1;
            S_J_PUSH:  begin mem_req = 1'b1; mem_we = 1'b1; raw_addr = push_addr; mem_wdata = lval_q; end
            S_J_SP:    begin rf_we = 1'b1; rf_idx = RI'(SP_IDX); rf_wdata = push_addr; end
            S_J_LINK:  begin rf_we = 1'b1; rf_idx = lnk_q;       rf_wdata = pc_q; end
            S_J_PC:    begin rf_we = 1'b1; rf_idx = RI'(PC_IDX); rf_wdata = ea_q; end
            S_M_SP:    begin rf_we = 1'b1; rf_idx = RI'(SP_IDX); rf_wdata = frame_sp; end
            S_M_PC:    begin rf_we = 1'b1; rf_idx = RI'(PC_IDX); rf_wdata = r5_q; end
            S_M_POP:   begin mem_req = 1'b1; raw_addr = frame_sp; end
            S_M_R5:    begin rf_we = 1'b1; rf_idx = RI'(FP_IDX); rf_wdata = pop_q; end
            S_M_SPINC: begin rf_we = 1'b1; rf_idx = RI'(SP_IDX); rf_wdata = after_pop; end
            S_DONE:    done = 1'b1;
            default:   ;
        endcase
        mem_addr = {raw_addr[W-1:1], 1'b0};
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) // R9
        else $error("AST_REQ_HELD");
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (!trap && !busy)) // R5
        else $error("AST_TRAP_PULSE");
    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!rf_we && !mem_req && !done)) // R2
        else $error("AST_TRAP_QUIET");
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !mem_req) // R6
        else $error("AST_ONE_ACTION");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)) // R10
        else $error("AST_DONE_PULSE");
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) // R10
        else $error("AST_START_TAKEN");
endmodule

// File: tb/link_mark_seq_tb.sv
module link_mark_seq_tb;
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [15:0] instr = '0, eff_addr = '0;
    logic [127:0] reg_bus;
    logic mem_req, mem_we, mem_ready, rf_we, busy, done, trap;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_wdata;
    logic [2:0] rf_idx;

    always #5 clk = ~clk;

    link_mark_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .eff_addr(eff_addr),
        .reg_bus(reg_bus), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .busy(busy), .done(done), .trap(trap)
    );

    // behavioural register file and stack memory
    logic [15:0] rf [8];
    logic [15:0] mem [256];
    logic        ld_rf = 1'b0, ld_mem = 1'b0;
    logic [15:0] ld_vals [8];
    logic [15:0] ld_addr = '0, ld_val = '0;
    int gap = 0;
    int wcnt;

    for (genvar g = 0; g < 8; g++) begin : g_bus
        assign reg_bus[g*16 +: 16] = rf[g];
    end
    assign mem_rdata = mem[mem_addr[8:1]];
    assign mem_ready = mem_req && (wcnt >= gap);

    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0; else wcnt <= wcnt + 1;
        if (ld_rf) begin
            for (int i = 0; i < 8; i++) rf[i] <= ld_vals[i];
        end else if (rf_we) rf[rf_idx] <= rf_wdata;
        if (ld_mem) mem[ld_addr[8:1]] <= ld_val;
        else if (mem_req && mem_ready && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    end

    // expected event stream
    typedef struct { int kind; int idx; logic [15:0] addr; logic [15:0] data; string tag; } ev_t;
    ev_t q[$];
    int checks = 0, errors = 0;
    logic chk_en = 1'b0;
    logic prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;

    function automatic void ev(int k, int i, logic [15:0] a, logic [15:0] d, string t);
        ev_t e;
        e.kind = k; e.idx = i; e.addr = a; e.data = d; e.tag = t;
        q.push_back(e);
    endfunction

    function automatic void chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            int nobs;
            int ok, oi;
            logic [15:0] oa, od;
            chk(busy === (q.size() != 0), "R10", "busy", int'(busy), int'(q.size() != 0));
            if (mem_req) chk(mem_addr[0] == 1'b0, "R11", "addr lsb", int'(mem_addr), 0);
            if (prev_stall) chk(mem_req && mem_addr == prev_addr, "R9", "held addr", int'(mem_addr), int'(prev_addr));
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            nobs = int'(rf_we) + int'(mem_req && mem_ready) + int'(done) + int'(trap);
            if (nobs > 1) chk(0, "R6", "events per cycle", nobs, 1);
            else if (nobs == 1) begin
                if (rf_we)              begin ok = 0; oi = int'(rf_idx); oa = '0; od = rf_wdata; end
                else if (mem_req && mem_we) begin ok = 1; oi = 0; oa = mem_addr; od = mem_wdata; end
                else if (mem_req)       begin ok = 2; oi = 0; oa = mem_addr; od = mem_rdata; end
                else if (done)          begin ok = 3; oi = 0; oa = '0; od = '0; end
                else                    begin ok = 4; oi = 0; oa = '0; od = '0; end
                if (q.size() == 0) chk(0, "R10", "unexpected event kind", ok, -1);
                else begin
                    ev_t e;
                    e = q.pop_front();
                    chk(ok == e.kind, e.tag, "event kind", ok, e.kind);
                    chk(oi == e.idx && oa == e.addr && od == e.data, e.tag, "event idx/addr/data",
                        int'({oi[2:0], od}), int'({e.idx[2:0], e.data}));
                    if (oa != e.addr) chk(0, e.tag, "event addr", int'(oa), int'(e.addr));
                end
            end
        end
    end

    task automatic load_regs(input logic [15:0] v [8]);
        @(negedge clk); #1;
        for (int i = 0; i < 8; i++) ld_vals[i] = v[i];
        ld_rf = 1'b1;
        @(negedge clk); #1 ld_rf = 1'b0;
    endtask

    task automatic load_mem(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); #1; ld_addr = a; ld_val = d; ld_mem = 1'b1;
        @(negedge clk); #1 ld_mem = 1'b0;
    endtask

    // independent model: fills the expected queue for one start
    task automatic issue(input logic [15:0] w, input logic [15:0] ea, input string trap_tag);
        logic [15:0] sp, pc, nsp, pv;
        int lk;
        @(negedge clk); #1;
        sp = rf[6]; pc = rf[7];
        if (w[15:9] == 7'b0000100) begin
            lk = int'(w[8:6]);
            if (lk == 6 || (lk == int'(w[2:0]) && lk != 7) || w[5:3] == 3'd0)
                ev(4, 0, 16'h0, 16'h0, trap_tag);
            else begin
                ev(1, 0, sp - 16'd2, rf[lk], "R6");
                ev(0, 6, 16'h0, sp - 16'd2, "R6");
                ev(0, lk, 16'h0, pc, "R6");
                ev(0, 7, 16'h0, ea, "R7");
                ev(3, 0, 16'h0, 16'h0, "R10");
            end
        end else if (w[15:6] == 10'b0000110100) begin
            nsp = pc + {9'd0, w[5:0], 1'b0};
            pv = mem[nsp[8:1]];
            ev(0, 6, 16'h0, nsp, "R8");
            ev(0, 7, 16'h0, rf[5], "R8");
            ev(2, 0, nsp, pv, "R8");
            ev(0, 5, 16'h0, pv, "R8");
            ev(0, 6, 16'h0, nsp + 16'd2, "R8");
            ev(3, 0, 16'h0, 16'h0, "R10");
        end else
            ev(4, 0, 16'h0, 16'h0, trap_tag);
        instr = w; eff_addr = ea; start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    task automatic finish_op();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_rf(input logic [15:0] e [8], input string tag);
        for (int i = 0; i < 8; i++)
            chk(rf[i] == e[i], tag, $sformatf("final R%0d", i), int'(rf[i]), int'(e[i]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] base [8];
        logic [15:0] exp_rf [8];
        for (int i = 0; i < 8; i++) base[i] = 16'h1000 + 16'(i * 16'h0111);
        base[6] = 16'h0400; base[7] = 16'h0200; base[5] = 16'hAAAA;
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !done && !trap && !rf_we && !mem_req, "R10", "reset outputs",
            int'({busy, done, trap, rf_we, mem_req}), 0);
        #1 rst_n = 1'b1;
        load_regs(base);
        chk_en = 1'b1;

        // R6/R7: jump, link R5, dst mode 1 R3, no stall
        gap = 0;
        issue(16'o004513, 16'h1234, "R1");
        finish_op();
        exp_rf = base; exp_rf[6] = 16'h03FE; exp_rf[5] = 16'h0200; exp_rf[7] = 16'h1234;
        check_rf(exp_rf, "R6");
        chk(mem[9'h3FE >> 1] == 16'hAAAA, "R6", "pushed link", int'(mem[9'h3FE >> 1]), 16'hAAAA);

        // R6: link PC, dst mode 3 R7, with stall of 2
        load_regs(base);
        gap = 2;
        issue(16'o004737, 16'h0F00, "R1");
        finish_op();
        exp_rf = base; exp_rf[6] = 16'h03FE; exp_rf[7] = 16'h0F00;
        check_rf(exp_rf, "R7");
        chk(mem[9'h3FE >> 1] == 16'h0200, "R6", "pushed PC", int'(mem[9'h3FE >> 1]), 16'h0200);

        // R3 exception: link = dst = 7 is legal
        load_regs(base);
        gap = 1;
        issue(16'o004767, 16'h2222, "R3");
        finish_op();
        exp_rf = base; exp_rf[6] = 16'h03FE; exp_rf[7] = 16'h2222;
        check_rf(exp_rf, "R3");

        // R2: SP as link
        load_regs(base);
        issue(16'o004613, 16'h3333, "R2");
        chk(trap === 1'b1, "R5", "trap cycle after start", int'(trap), 1);
        @(negedge clk); #1;
        chk(trap === 1'b0 && done === 1'b0, "R5", "trap one cycle", int'({trap, done}), 0);
        finish_op();
        check_rf(base, "R2");

        // R3: link equals destination register
        issue(16'o004313, 16'h3333, "R3");
        finish_op();
        check_rf(base, "R3");

        // R4: register-direct destination
        issue(16'o004502, 16'h3333, "R4");
        finish_op();
        check_rf(base, "R4");

        // R1: unrecognised word
        issue(16'o005000, 16'h3333, "R1");
        finish_op();
        check_rf(base, "R1");

        // R8: mark n=3, stall of 3
        load_mem(16'h0306, 16'hBEEF);
        base[7] = 16'h0300; base[5] = 16'h0500;
        load_regs(base);
        gap = 3;
        issue(16'o006403, 16'h0000, "R1");
        finish_op();
        exp_rf = base; exp_rf[7] = 16'h0500; exp_rf[5] = 16'hBEEF; exp_rf[6] = 16'h0308;
        check_rf(exp_rf, "R8");

        // R8: mark with wrap, n=63
        load_mem(16'h006E, 16'h7A5C);
        base[7] = 16'hFFF0; base[5] = 16'h0044;
        load_regs(base);
        gap = 0;
        issue(16'o006477, 16'h0000, "R1");
        finish_op();
        exp_rf = base; exp_rf[7] = 16'h0044; exp_rf[5] = 16'h7A5C; exp_rf[6] = 16'h0070;
        check_rf(exp_rf, "R8");

        // R10: start while busy (stalled push) is ignored
        base[7] = 16'h0200; base[6] = 16'h0400; base[5] = 16'hAAAA;
        load_regs(base);
        gap = 3;
        issue(16'o004513, 16'h4444, "R1");
        @(negedge clk); #1; instr = 16'o004613; start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        finish_op();
        exp_rf = base; exp_rf[6] = 16'h03FE; exp_rf[5] = 16'h0200; exp_rf[7] = 16'h4444;
        check_rf(exp_rf, "R10");
        chk(!busy && !trap, "R10", "idle after ignored start", int'({busy, trap}), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule